// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block gives a host a narrow window into an 8-bit PHY register file. The host never addresses PHY registers directly. Instead it sees two host registers: a command register and a data register. Every PHY access is a short two-register exchange.

For a PHY write, the host first puts the byte into the data register. It then writes the command register with the PHY offset and the write bit set. For a PHY read, the host clears the data register and writes the offset with the write bit clear. In both cases it then polls the busy flag until the flag drops. After a read, it picks up the byte from the data register.

The writing of the command register is what launches the transaction. A PHY-side register port with a parameterised access latency finishes each access with a single acknowledge pulse.

Top module: `ipb_bridge`

## Requirements
- R1: After reset, the command register (host offset 0x300) and the data register (host offset 0x304) both read as zero.
- R2: A read of the command register returns:
  - bits [7:0]: the last accepted PHY offset;
  - bit 8: the last accepted write/read select, 1 = write;
  - bit 9: busy;
  - bit 10: the error flag;
  - all other bits: zero.

  A read of any other host offset returns zero.
- R3: A command-register write that is accepted shows busy = 1 from the clock edge that accepts it. It starts exactly one PHY access.
- R4: Busy stays set for PHY_LAT + 1 cycles, counted from the accepting edge. It then clears by itself.
- R5: A command with bit 8 = 1 stores bits [7:0] of the data register into the PHY register at the given offset.
- R6: A command with bit 8 = 0 loads the addressed PHY register into bits [7:0] of the data register. The remaining data-register bits read zero.
- R7: While idle, a host write to the data register stores bits [7:0] of the write data. Readback returns only those bits.
- R8: A command-register write while busy is ignored. The offset, the write select and the PHY registers are all left untouched. The sticky error flag (bit 10) is set.
- R9: A data-register write while busy is ignored.
- R10: An accepted command-register write that has bit 10 = 1 clears the error flag. It also launches its transaction.
- R11: A PHY register that has not been written since reset reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWr | input | 1 | Host write strobe, one cycle per write |
| hostAddr | input | 12 | Host register offset |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, combinational from hostAddr |

## Verification
Two events can meet in one cycle: the PHY acknowledge that ends a transaction, and a new host command. In the cycle of the acknowledge, busy is still set, so a command arriving then must be refused and flagged.

The bench times a command write so that its accepting edge is the same edge at which busy falls. It then judges the outcome on four points:
- busy is clear;
- the error flag is set;
- the old offset is retained;
- the refused target register still reads zero.

A similar collision pits a host data write against the read capture. It is judged by the captured PHY byte surviving.

// File: rtl/ipb_pkg.sv
package ipb_pkg;
  localparam int WR_BIT   = 8;
  localparam int BUSY_BIT = 9;
  localparam int ERR_BIT  = 10;

  typedef struct packed {
    logic loadCmd;
    logic loadData;
    logic capture;
    logic setErr;
    logic clrErr;
  } ctlStrobe_t;
endpackage

// File: rtl/ipb_control.sv
module ipb_control
  import ipb_pkg::*;
#(
  parameter int HOST_AW = 12,
  parameter logic [HOST_AW-1:0] CMD_OFS  = 12'h300,
  parameter logic [HOST_AW-1:0] DATA_OFS = 12'h304
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWr,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               errClrBit,
  input  logic               cmdWr,
  input  logic               phyAck,
  output logic               phyReq,
  output logic               busy,
  output ctlStrobe_t         strobe
);
  logic cmdHit, dataHit, reqQ, busyQ;

  assign cmdHit  = hostWr && (hostAddr == CMD_OFS);
  assign dataHit = hostWr && (hostAddr == DATA_OFS);

  always_comb begin
    strobe          = '0;
    strobe.loadCmd  = cmdHit && !busyQ;
    strobe.loadData = dataHit && !busyQ;
    strobe.capture  = phyAck && !cmdWr;
    strobe.setErr   = cmdHit && busyQ;
    strobe.clrErr   = cmdHit && !busyQ && errClrBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      reqQ  <= 1'b0;
    end else if (strobe.loadCmd) begin
      busyQ <= 1'b1;
      reqQ  <= 1'b1;
    end else if (phyAck) begin
      busyQ <= 1'b0;
      reqQ  <= 1'b0;
    end
  end

  assign phyReq = reqQ;
  assign busy   = busyQ;

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHit && !busyQ) |=> busyQ);
  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> $past(phyAck));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !phyAck) |=> busyQ);
endmodule

// File: rtl/ipb_datapath.sv
module ipb_datapath
  import ipb_pkg::*;
#(
  parameter int HOST_AW = 12,
  parameter int HOST_DW = 32,
  parameter int PHY_AW  = 8,
  parameter int PHY_DW  = 8,
  parameter logic [HOST_AW-1:0] CMD_OFS  = 12'h300,
  parameter logic [HOST_AW-1:0] DATA_OFS = 12'h304
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [HOST_DW-1:0] hostWdata,
  input  logic               busy,
  input  logic [PHY_DW-1:0]  phyRdata,
  output logic [PHY_AW-1:0]  cmdOfs,
  output logic               cmdWr,
  output logic [PHY_DW-1:0]  dataByte,
  output logic [HOST_DW-1:0] hostRdata
);
  logic errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOfs   <= '0;
      cmdWr    <= 1'b0;
      dataByte <= '0;
      errQ     <= 1'b0;
    end else begin
      if (strobe.loadCmd) begin
        cmdOfs <= hostWdata[PHY_AW-1:0];
        cmdWr  <= hostWdata[WR_BIT];
      end
      if (strobe.capture)       dataByte <= phyRdata;
      else if (strobe.loadData) dataByte <= hostWdata[PHY_DW-1:0];
      if (strobe.setErr)        errQ <= 1'b1;
      else if (strobe.clrErr)   errQ <= 1'b0;
    end
  end

  always_comb begin
    hostRdata = '0;
    if (hostAddr == CMD_OFS) begin
      hostRdata[PHY_AW-1:0] = cmdOfs;
      hostRdata[WR_BIT]     = cmdWr;
      hostRdata[BUSY_BIT]   = busy;
      hostRdata[ERR_BIT]    = errQ;
    end else if (hostAddr == DATA_OFS) begin
      hostRdata[PHY_DW-1:0] = dataByte;
    end
  end

  // R9
  data_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.capture) |=> $stable(dataByte));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !strobe.clrErr) |=> errQ);
  // R8
  cmd_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(cmdOfs) && $stable(cmdWr)));
endmodule

// File: rtl/ipb_phy_port.sv
module ipb_phy_port #(
  parameter int PHY_AW  = 8,
  parameter int PHY_DW  = 8,
  parameter int PHY_LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [PHY_AW-1:0] addr,
  input  logic [PHY_DW-1:0] wdata,
  output logic              ack,
  output logic [PHY_DW-1:0] rdata
);
  localparam int DEPTH = 1 << PHY_AW;
  localparam int CW    = $clog2(PHY_LAT) + 1;
  localparam logic [CW-1:0] LAST = CW'(PHY_LAT - 1);

  logic [PHY_DW-1:0] regFile [DEPTH];
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      ack   <= 1'b0;
      rdata <= '0;
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else if (req && !ack) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        ack   <= 1'b1;
        rdata <= regFile[addr];
        if (we) regFile[addr] <= wdata;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      ack <= 1'b0;
      cnt <= '0;
    end
  end

  // R3
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> req);
  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);
endmodule

// File: rtl/ipb_bridge.sv
module ipb_bridge
  import ipb_pkg::*;
#(
  parameter int HOST_AW = 12,
  parameter int HOST_DW = 32,
  parameter int PHY_AW  = 8,
  parameter int PHY_DW  = 8,
  parameter int PHY_LAT = 3,
  parameter logic [HOST_AW-1:0] CMD_OFS  = 12'h300,
  parameter logic [HOST_AW-1:0] DATA_OFS = 12'h304
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWr,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [HOST_DW-1:0] hostWdata,
  output logic [HOST_DW-1:0] hostRdata
);
  ctlStrobe_t        strobe;
  logic              busy, phyReq, phyAck, cmdWr;
  logic [PHY_AW-1:0] cmdOfs;
  logic [PHY_DW-1:0] dataByte, phyRdata;

  ipb_control #(.HOST_AW(HOST_AW), .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS)) u_ctl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .errClrBit(hostWdata[ERR_BIT]), .cmdWr(cmdWr), .phyAck(phyAck),
    .phyReq(phyReq), .busy(busy), .strobe(strobe)
  );

  ipb_datapath #(.HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .PHY_AW(PHY_AW),
                 .PHY_DW(PHY_DW), .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .busy(busy), .phyRdata(phyRdata),
    .cmdOfs(cmdOfs), .cmdWr(cmdWr), .dataByte(dataByte), .hostRdata(hostRdata)
  );

  ipb_phy_port #(.PHY_AW(PHY_AW), .PHY_DW(PHY_DW), .PHY_LAT(PHY_LAT)) u_phy (
    .clk(clk), .rstN(rstN), .req(phyReq), .we(cmdWr), .addr(cmdOfs),
    .wdata(dataByte), .ack(phyAck), .rdata(phyRdata)
  );
endmodule

// File: tb/ipb_bridge_bench.sv
`timescale 1ns/1ps
module ipb_bridge_bench;
  localparam int LAT = 3;
  localparam logic [11:0] CMD  = 12'h300;
  localparam logic [11:0] DATA = 12'h304;
  // entry: [16] 1=PHY write, 0=PHY read; [15:8] PHY offset; [7:0] data or expected byte
  localparam logic [16:0] VEC [8] = '{
    17'h1_00A5, 17'h1_123C, 17'h1_FF81, 17'h1_240F,
    17'h0_123C, 17'h0_FF81, 17'h0_00A5, 17'h0_240F
  };

  logic        clk = 1'b0;
  logic        rstN, hostWr;
  logic [11:0] hostAddr;
  logic [31:0] hostWdata, hostRdata;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ipb_bridge #(.PHY_LAT(LAT)) u_ipb_bridge (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    hostAddr = a;
    #1;
    d = hostRdata;
  endtask

  task automatic waitIdle(output int n);
    logic [31:0] v;
    n = 0;
    rd(CMD, v);
    while (v[9] && n < 100) begin
      n++;
      @(negedge clk);
      rd(CMD, v);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    rstN = 1'b0; hostWr = 1'b0; hostAddr = '0; hostWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    rd(CMD, r);  check("R1 cmd reset", r, 32'h0);
    rd(DATA, r); check("R1 data reset", r, 32'h0);
    rd(12'h308, r); check("R2 unmapped", r, 32'h0);

    wr(DATA, 32'hFFFF_FF5A);
    rd(DATA, r); check("R7 data load", r, 32'h5A);

    // table walk: PHY writes then PHY reads
    for (int i = 0; i < 8; i++) begin
      logic [16:0] v;
      v = VEC[i];
      if (v[16]) begin
        wr(DATA, {24'h0, v[7:0]});
        wr(CMD, {23'h0, 1'b1, v[15:8]});
        waitIdle(n); check("R4 busy len (write)", n, LAT + 1);
      end else begin
        wr(DATA, 32'h0);
        wr(CMD, {24'h0, v[15:8]});
        waitIdle(n); check("R4 busy len (read)", n, LAT + 1);
        rd(DATA, r); check("R6 read byte", r, {24'h0, v[7:0]});
      end
    end

    // R2 / R3 / R5 directed
    wr(DATA, 32'h77);
    wr(CMD, 32'h0000_0133);
    rd(CMD, r); check("R3 busy at once", r, 32'h333);
    waitIdle(n);
    rd(CMD, r); check("R2 cmd readback", r, 32'h133);
    wr(DATA, 32'h0);
    wr(CMD, 32'h33);
    waitIdle(n);
    rd(DATA, r); check("R5 write landed", r, 32'h77);

    // R8: command arrives on the edge where busy falls
    wr(DATA, 32'h0);
    wr(CMD, 32'h12);
    repeat (LAT - 1) @(negedge clk);
    wr(CMD, 32'h144);
    rd(CMD, r);  check("R8 refused cmd, err set", r, 32'h412);
    rd(DATA, r); check("R8 read completed", r, 32'h3C);

    // R9: data write during a read
    wr(DATA, 32'h0);
    wr(CMD, 32'h00);
    wr(DATA, 32'h99);
    waitIdle(n);
    rd(DATA, r); check("R9 data write ignored", r, 32'hA5);
    rd(CMD, r);  check("R8 err sticky", r, 32'h400);

    // R10 / R11: clear error while reading an untouched register (0x44 also proves R8 no access)
    wr(CMD, 32'h444);
    waitIdle(n);
    rd(CMD, r);  check("R10 err cleared", r, 32'h044);
    rd(DATA, r); check("R11 untouched reg zero", r, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule